// File: doc/BRIEF.md
# Interrupt Control and Status Register Pair with Software Reset

This block holds two software-visible registers. The control register carries a software reset bit and one enable bit per interrupt source. The status register records which sources have raised a request. There are five sources: a general interrupt, two bus-side error reports, a parity error and a system error. A source that asserts while its enable is set latches its status bit. The bit stays set until software writes a one to it. The block drives a single combined interrupt line and a soft-reset line.

Software reaches the registers through a minimal port: a select line chooses the register, a write strobe with a 32-bit data word updates it, and the read word follows the select line combinationally. A build parameter picks the host or the guest variant. The guest variant has no system-error or parity-error source, so those bits read as zero in both registers.

Register bit layout, which software decodes. Control word: bit 31 is the software reset and bits 4..0 are the enables. Status word: bits 4..0 are the pending flags. The bit order is 4 system error, 3 parity error, 2 and 1 the two bus-side errors, 0 general interrupt. Select value 0 addresses the control word and 1 addresses the status word.

Top module: `irq_ctl_regs`

## Requirements
- R1: After synchronous reset, both registers read as zero, and irq_out and soft_rst_out are low.
- R2: A control write (reg_sel=0) stores data bit 31 and drives it on soft_rst_out from the next cycle. The bit holds until a later control write changes it.
- R3: When src_req[i] is high at a clock edge and enable bit i is set, status bit i reads 1 after that edge.
- R4: A source whose enable bit is clear never sets its status bit.
- R5: A status write (reg_sel=1) clears each status bit whose data bit is 1. Status bits whose data bit is 0 are unchanged.
- R6: If a source sets a status bit in the same cycle that software clears it, the bit stays set.
- R7: irq_out is high exactly when at least one status bit is set.
- R8: Control bits 30..5 and status bits 31..5 always read as zero, whatever value is written.
- R9: In the guest build (HOST_BUILD=0), bits 4..3 of both registers always read as zero, and those status bits cannot be set.
- R10: A set status bit stays set after its source deasserts and after its enable is cleared, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 5 | Interrupt requests: bit 4 system error, 3 parity, 2/1 bus-side errors, 0 general |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Contents of the selected register |
| irq_out | output | 1 | Combined interrupt request |
| soft_rst_out | output | 1 | Software reset request |

## Verification
Two events can fall on the same edge: a source request setting a status bit, and a write-one-to-clear from software aimed at that same bit. The bench drives both in one cycle and checks that the bit reads as set afterwards. It also checks that a clear of a different bit in that cycle still takes effect. Two instances run side by side, one host and one guest. Every combination of the 32 enable patterns and the 32 request patterns is swept, and each read-back is compared with the request pattern ANDed with the enables and with the build's implemented-bit mask.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int NSRC        = 5;   // number of interrupt sources
    localparam int DW          = 32;  // register width
    localparam int SOFT_RST_B  = 31;  // software reset position in control word

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic            soft_rst;
        logic [NSRC-1:0] en;
    } ctrl_t;

    // Sources that exist in a given build: host has all, guest drops 4..3
    function automatic logic [NSRC-1:0] impl_mask(input bit host);
        return host ? {NSRC{1'b1}} : {{(NSRC-3){1'b0}}, 3'b111};
    endfunction

    function automatic logic [DW-1:0] pack_ctrl(input ctrl_t c);
        logic [DW-1:0] w;
        w = '0;
        w[SOFT_RST_B] = c.soft_rst;
        w[NSRC-1:0]   = c.en;
        return w;
    endfunction

    function automatic logic [DW-1:0] pack_stat(input logic [NSRC-1:0] s);
        logic [DW-1:0] w;
        w = '0;
        w[NSRC-1:0] = s;
        return w;
    endfunction
endpackage

// File: rtl/irq_ctl_cfg.sv
module irq_ctl_cfg
    import irq_ctl_pkg::*;
#(
    parameter bit HOST_BUILD = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_i,
    input  logic            soft_i,
    input  logic [NSRC-1:0] en_i,
    output ctrl_t           ctrl_o
);
    localparam logic [NSRC-1:0] MASK = impl_mask(HOST_BUILD);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_i) begin
            ctrl_q.soft_rst <= soft_i;
            ctrl_q.en       <= en_i & MASK;
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/irq_stat_cell.sv
module irq_stat_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    // a request beats a simultaneous software clear
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assign q_o = q;
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_ctl_pkg::*;
#(
    parameter bit HOST_BUILD = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_req,
    input  logic            reg_sel,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   rd_data,
    output logic            irq_out,
    output logic            soft_rst_out
);
    localparam logic [NSRC-1:0] MASK = impl_mask(HOST_BUILD);

    reg_sel_e        sel;
    ctrl_t           ctrl_q;
    logic [NSRC-1:0] status_q;
    logic            ctrl_wr;
    logic            stat_wr;
    logic            unused_bits;

    assign sel     = reg_sel_e'(reg_sel);
    assign ctrl_wr = wr_en && (sel == SEL_CTRL);
    assign stat_wr = wr_en && (sel == SEL_STAT);

    irq_ctl_cfg #(.HOST_BUILD(HOST_BUILD)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (ctrl_wr),
        .soft_i (wr_data[SOFT_RST_B]),
        .en_i   (wr_data[NSRC-1:0]),
        .ctrl_o (ctrl_q)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (MASK[i]) begin : g_impl
            irq_stat_cell u_cell (
                .clk   (clk),
                .rst   (rst),
                .set_i (src_req[i] & ctrl_q.en[i]),
                .clr_i (stat_wr & wr_data[i]),
                .q_o   (status_q[i])
            );
        end else begin : g_absent
            assign status_q[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rd_data = pack_ctrl(ctrl_q);
            SEL_STAT: rd_data = pack_stat(status_q);
            default:  rd_data = '0;
        endcase
    end

    assign irq_out      = |status_q;
    assign soft_rst_out = ctrl_q.soft_rst;

    assign unused_bits = ^{wr_data[SOFT_RST_B-1:NSRC], src_req};
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk
    import irq_ctl_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] src_req,
    input logic            reg_sel,
    input logic            wr_en,
    input logic [NSRC-1:0] wr_lo,
    input logic            irq_out,
    input logic            soft_rst_out,
    input logic [NSRC-1:0] status_q,
    input logic [NSRC-1:0] en_q
);
    // R3 / R6: an enabled request is latched, even against a clear
    p_set_latch_r3: assert property (@(posedge clk) disable iff (rst)
        ((src_req & en_q) != '0) |=>
            ((status_q & $past(src_req & en_q)) == $past(src_req & en_q)));

    // R5: bits cleared by software and not re-requested are low afterwards
    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel) |=>
            ((status_q & $past(wr_lo & ~(src_req & en_q))) == '0));

    // R10: without a status write, no pending bit drops
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && reg_sel) |=>
            ((status_q & $past(status_q)) == $past(status_q)));

    // R7: the interrupt line only rises after an enabled request
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> ($past(src_req & en_q) != '0));

    // R2: soft reset changes only through a control write
    p_soft_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && !reg_sel) |=> $stable(soft_rst_out));
endmodule

bind irq_ctl_regs irq_ctl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .src_req      (src_req),
    .reg_sel      (reg_sel),
    .wr_en        (wr_en),
    .wr_lo        (wr_data[irq_ctl_pkg::NSRC-1:0]),
    .irq_out      (irq_out),
    .soft_rst_out (soft_rst_out),
    .status_q     (status_q),
    .en_q         (ctrl_q.en)
);

// File: tb/test_irq_ctl_regs.sv
module test_irq_ctl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  src_req = '0;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_h, rd_g;
    logic        irq_h, irq_g, srst_h, srst_g;

    int total = 0;
    int bad   = 0;

    localparam logic [4:0] MH = 5'b11111;
    localparam logic [4:0] MG = 5'b00111;

    always #10 clk = ~clk;

    irq_ctl_regs #(.HOST_BUILD(1'b1)) i_irq_ctl_regs (
        .clk(clk), .rst(rst), .src_req(src_req), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_h),
        .irq_out(irq_h), .soft_rst_out(srst_h));

    irq_ctl_regs #(.HOST_BUILD(1'b0)) i_irq_ctl_regs_guest (
        .clk(clk), .rst(rst), .src_req(src_req), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_g),
        .irq_out(irq_g), .soft_rst_out(srst_g));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance one clock edge; inputs change only after a falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d, input logic [4:0] req);
        reg_sel = sel; wr_data = d; wr_en = 1'b1; src_req = req;
        cyc();
        wr_en = 1'b0; src_req = '0; wr_data = '0;
    endtask

    task automatic rd_stat(input string tag, input logic [4:0] eh, input logic [4:0] eg);
        reg_sel = 1'b1; #1;
        chk({tag, " host status"}, rd_h, {27'b0, eh});
        chk({tag, " guest status"}, rd_g, {27'b0, eg});
        chk({tag, " R7 host irq"}, {31'b0, irq_h}, {31'b0, |eh});
        chk({tag, " R7 guest irq"}, {31'b0, irq_g}, {31'b0, |eg});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc();
        rst = 1'b0;

        // R1 reset state
        reg_sel = 1'b0; #1;
        chk("R1 host ctrl", rd_h, 32'h0);
        chk("R1 guest ctrl", rd_g, 32'h0);
        chk("R1 soft rst", {30'b0, srst_h, srst_g}, 32'h0);
        rd_stat("R1", 5'h0, 5'h0);

        // R2, R8, R9: all-ones control write
        wr(1'b0, 32'hFFFF_FFFF, 5'h0);
        reg_sel = 1'b0; #1;
        chk("R8 host ctrl readback", rd_h, 32'h8000_001F);
        chk("R9 guest ctrl readback", rd_g, 32'h8000_0007);
        chk("R2 soft rst set", {30'b0, srst_h, srst_g}, 32'h3);
        repeat (4) cyc();
        chk("R2 soft rst held", {30'b0, srst_h, srst_g}, 32'h3);
        wr(1'b0, 32'h0000_001F, 5'h0);
        chk("R2 soft rst cleared", {30'b0, srst_h, srst_g}, 32'h0);

        // R3 R4 R9: sweep every enable pattern against every request pattern
        for (int e = 0; e < 32; e++) begin
            for (int s = 0; s < 32; s++) begin
                wr(1'b0, 32'(e), 5'h0);
                wr(1'b1, 32'h1F, 5'h0);
                src_req = 5'(s);
                cyc();
                src_req = '0;
                rd_stat("R3 R4 R9 sweep", 5'(s & e) & MH, 5'(s & e) & MG);
            end
        end

        // R10: hold after source drops and enables clear
        wr(1'b1, 32'h1F, 5'h0);
        wr(1'b0, 32'h1F, 5'h0);
        src_req = 5'h1F; cyc(); src_req = '0;
        wr(1'b0, 32'h0, 5'h0);
        repeat (3) cyc();
        rd_stat("R10 hold", MH, MG);

        // R8: writing upper status bits leaves everything; zeros clear nothing (R5)
        wr(1'b1, 32'hFFFF_FFE0, 5'h0);
        rd_stat("R8 R5 zero bits", MH, MG);

        // R5: partial clear
        wr(1'b1, 32'h0000_0005, 5'h0);
        rd_stat("R5 partial clear", MH & 5'h1A, MG & 5'h1A);

        // R6: set wins over a simultaneous clear of the same bit
        wr(1'b1, 32'h1F, 5'h0);
        wr(1'b0, 32'h1F, 5'h0);
        src_req = 5'h1;  cyc(); src_req = '0;   // bit 0 pending
        wr(1'b1, 32'h0000_0003, 5'h3);          // clear 1..0 while 1..0 request
        rd_stat("R6 set beats clear", 5'h3, 5'h3);
        wr(1'b1, 32'h0000_0003, 5'h2);          // clear both, only bit 1 requests
        rd_stat("R6 mixed", 5'h2, 5'h2);

        // R9: guest system/parity requests ignored even with all enables written
        wr(1'b1, 32'h1F, 5'h0);
        wr(1'b0, 32'h1F, 5'h0);
        src_req = 5'h18; cyc(); src_req = '0;
        rd_stat("R9 guest upper", 5'h18, 5'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule